// File: doc/BRIEF.md
# USB Host Transmit Pre-fill Gate

This block decides when a host-side OUT or SETUP packet may go onto the bus. When the schedule finds a transmit packet, the block first checks the time budget. The time left in the current frame or microframe must cover the estimated send time plus a programmable overhead. If it does, the block waits while the fetch engine posts data bursts into the transmit latency FIFO. It releases the packet once enough bursts are buffered. If the budget runs out before then, it abandons the attempt, asks for the partial FIFO contents to be flushed, and records a back-off.

Time is handled in one tick unit throughout. The remaining frame time and the packet estimate arrive in ticks. The overhead field is scaled to ticks by a multiplier parameter, and an input that selects high speed or full/low speed chooses which multiplier applies. When streaming is disabled, the burst threshold is bypassed. A 32-bit control/status word holds the overhead, the threshold and a saturating back-off counter that any write clears.

Top module: `usb_txfill_gate`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x0002_0000: overhead 0, back-off count 0, burst threshold 2.
- R2: The word layout is overhead in bits 7:0, back-off count in bits 12:8 and burst threshold in bits 21:16. A write loads overhead and threshold from `cfg_wr_data`. Bits 15:13 and 31:22 always read zero.
- R3: While idle, a `pkt_req` is accepted only if `frame_left >= pkt_est + overhead * M`. Otherwise it is dropped: no pulse follows, and later bursts start nothing.
- R4: M is `HS_MULT` (default 2) when `speed_hs` is 1 and `FS_MULT` (default 10) when it is 0.
- R5: With streaming enabled, an accepted attempt raises `start_packet` for one cycle. This happens in the cycle after the clock edge at which the count of `burst_posted` cycles seen during the attempt reaches the effective threshold.
- R6: A programmed threshold below 2 acts as 2.
- R7: With `stream_off` high, an accepted request raises `start_packet` in the next cycle with no bursts. If `stream_off` rises during pre-fill, the packet starts in the cycle after the next edge.
- R8: During pre-fill, if `frame_left` falls below the budget at a clock edge, `backoff` and `fifo_flush` are both high for exactly one cycle, no start follows, and the block returns to idle.
- R9: Each back-off increments the back-off count, visible in the same cycle as the `backoff` pulse. The count saturates at 31.
- R10: Any write clears the back-off count to 0 whatever the data. A write wins over a back-off at the same edge.
- R11: A `pkt_req` during pre-fill is ignored. Bursts posted while idle are not counted, because every attempt counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_data | output | 32 | Control/status word |
| speed_hs | input | 1 | 1 = high speed, 0 = full/low speed overhead scaling |
| stream_off | input | 1 | Streaming disabled: threshold bypassed |
| pkt_req | input | 1 | Transmit packet found by the schedule |
| frame_left | input | TICK_W | Ticks left in the current (micro)frame |
| pkt_est | input | TICK_W | Estimated packet send time in ticks |
| burst_posted | input | 1 | One data burst posted to the latency FIFO this cycle |
| start_packet | output | 1 | One-cycle pulse: release packet to bus |
| backoff | output | 1 | One-cycle pulse: attempt abandoned |
| fifo_flush | output | 1 | One-cycle pulse: discard partial FIFO data |

## Verification
Several properties are checked on every cycle. Start and back-off never coincide, and back-off never lasts more than one cycle. The reserved bits stay zero. The back-off count rises by one on each back-off, holds at 31, and reads zero after any write. The bench scenarios cover the rest. Sweeps over overhead, speed and estimate show the admission boundary at exactly the budget and one tick below it. Sweeps over thresholds show how many bursts release a packet. Other scenarios show the stream-disable bypass, a back-off triggered mid-fill, and requests or bursts being ignored in the wrong state.

// File: rtl/txg_pkg.sv
`timescale 1ns/1ps
// txg_pkg: shared types and field geometry for the transmit pre-fill gate.
// Assumes a 32-bit control word whose field positions are decoded by software.
package txg_pkg;
    localparam int OVH_W      = 8;
    localparam int HEALTH_W   = 5;
    localparam int THR_W      = 6;
    localparam int OVH_LSB    = 0;
    localparam int HEALTH_LSB = 8;
    localparam int THR_LSB    = 16;
    localparam int HEALTH_MAX = (1 << HEALTH_W) - 1;
    localparam int THR_MIN    = 2;
    localparam int THR_RESET  = 2;

    typedef enum logic {
        TXG_IDLE = 1'b0,
        TXG_FILL = 1'b1
    } txg_state_e;
endpackage

// File: rtl/txg_regs.sv
`timescale 1ns/1ps
// txg_regs: control/status word holding overhead, burst threshold and the
// saturating back-off count. Assumes bo_evt marks the edge at which a
// back-off is decided; a write at that same edge takes priority.
module txg_regs
    import txg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    input  logic                bo_evt,
    output logic [OVH_W-1:0]    ovh_o,
    output logic [THR_W-1:0]    thr_o,
    output logic [31:0]         rd_data
);
    logic [HEALTH_W-1:0] health_q;

    // Overhead and threshold: loaded on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovh_o <= '0;
            thr_o <= THR_W'(THR_RESET);
        end else if (wr_en) begin
            ovh_o <= wr_data[OVH_LSB +: OVH_W];
            thr_o <= wr_data[THR_LSB +: THR_W];
        end
    end

    // Back-off count: cleared by any write, else saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            health_q <= '0;
        end else if (wr_en) begin
            health_q <= '0;
        end else if (bo_evt && (health_q != HEALTH_W'(HEALTH_MAX))) begin
            health_q <= health_q + 1'b1;
        end
    end

    // Read word assembly; unused bits stay zero.
    always_comb begin
        rd_data = '0;
        rd_data[OVH_LSB +: OVH_W]       = ovh_o;
        rd_data[HEALTH_LSB +: HEALTH_W] = health_q;
        rd_data[THR_LSB +: THR_W]       = thr_o;
    end
endmodule

// File: rtl/txg_budget.sv
`timescale 1ns/1ps
// txg_budget: decides whether the frame time left covers the packet estimate
// plus the speed-scaled overhead. Assumes both times use the same tick unit.
module txg_budget
    import txg_pkg::*;
#(
    parameter int TICK_W  = 16,
    parameter int MULT_W  = 8,
    parameter int HS_MULT = 2,
    parameter int FS_MULT = 10
) (
    input  logic [TICK_W-1:0] frame_left,
    input  logic [TICK_W-1:0] pkt_est,
    input  logic [OVH_W-1:0]  ovh,
    input  logic              speed_hs,
    output logic              fits
);
    localparam int PROD_W = OVH_W + MULT_W;
    localparam int NEED_W = ((TICK_W > PROD_W) ? TICK_W : PROD_W) + 1;

    logic [MULT_W-1:0] mult;
    logic [NEED_W-1:0] need;

    // Per-speed multiplier selection.
    always_comb mult = speed_hs ? MULT_W'(HS_MULT) : MULT_W'(FS_MULT);

    // Budget = estimate + overhead in ticks; compare with the time left.
    always_comb begin
        need = NEED_W'(pkt_est) + (NEED_W'(ovh) * NEED_W'(mult));
        fits = (NEED_W'(frame_left) >= need);
    end
endmodule

// File: rtl/txg_fsm.sv
`timescale 1ns/1ps
// txg_fsm: admission, burst counting and release/abort control. Assumes
// burst_posted is high for one cycle per burst and fits is re-evaluated
// every cycle. Output pulses are registered.
module txg_fsm
    import txg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             fits,
    input  logic             stream_off,
    input  logic             burst,
    input  logic [THR_W-1:0] thr,
    output logic             start_packet,
    output logic             backoff,
    output logic             fifo_flush,
    output logic             bo_evt
);
    txg_state_e       state_q, state_d;
    logic [THR_W-1:0] cnt_q, cnt_d;
    logic [THR_W:0]   cnt_inc;
    logic [THR_W-1:0] eff_thr;
    logic             go;

    // Threshold clamp: values below the minimum act as the minimum.
    always_comb eff_thr = (thr < THR_W'(THR_MIN)) ? THR_W'(THR_MIN) : thr;

    // Burst count including this cycle's burst.
    always_comb cnt_inc = {1'b0, cnt_q} + {{THR_W{1'b0}}, burst};

    // Next-state decision; the time check outranks release.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        go      = 1'b0;
        bo_evt  = 1'b0;
        unique case (state_q)
            TXG_IDLE: begin
                cnt_d = '0;
                if (req && fits) begin
                    if (stream_off) go = 1'b1;
                    else            state_d = TXG_FILL;
                end
            end
            TXG_FILL: begin
                if (!fits) begin
                    bo_evt  = 1'b1;
                    state_d = TXG_IDLE;
                end else if (stream_off || (cnt_inc >= {1'b0, eff_thr})) begin
                    go      = 1'b1;
                    state_d = TXG_IDLE;
                end else begin
                    cnt_d = cnt_inc[THR_W-1:0];
                end
            end
            default: state_d = TXG_IDLE;
        endcase
    end

    // State, counter and registered output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= TXG_IDLE;
            cnt_q        <= '0;
            start_packet <= 1'b0;
            backoff      <= 1'b0;
            fifo_flush   <= 1'b0;
        end else begin
            state_q      <= state_d;
            cnt_q        <= cnt_d;
            start_packet <= go;
            backoff      <= bo_evt;
            fifo_flush   <= bo_evt;
        end
    end
endmodule

// File: rtl/usb_txfill_gate.sv
`timescale 1ns/1ps
// usb_txfill_gate: gates the start of a host transmit packet on a frame-time
// budget and a buffered-burst threshold, aborting with a flush and a counted
// back-off when time runs short. Assumes synchronous inputs in one clock domain.
module usb_txfill_gate
    import txg_pkg::*;
#(
    parameter int TICK_W  = 16,
    parameter int MULT_W  = 8,
    parameter int HS_MULT = 2,
    parameter int FS_MULT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       cfg_rd_data,
    input  logic              speed_hs,
    input  logic              stream_off,
    input  logic              pkt_req,
    input  logic [TICK_W-1:0] frame_left,
    input  logic [TICK_W-1:0] pkt_est,
    input  logic              burst_posted,
    output logic              start_packet,
    output logic              backoff,
    output logic              fifo_flush
);
    logic [OVH_W-1:0] ovh;
    logic [THR_W-1:0] thr;
    logic             fits;
    logic             bo_evt;

    txg_regs regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .bo_evt  (bo_evt),
        .ovh_o   (ovh),
        .thr_o   (thr),
        .rd_data (cfg_rd_data)
    );

    txg_budget #(
        .TICK_W  (TICK_W),
        .MULT_W  (MULT_W),
        .HS_MULT (HS_MULT),
        .FS_MULT (FS_MULT)
    ) budget_i (
        .frame_left (frame_left),
        .pkt_est    (pkt_est),
        .ovh        (ovh),
        .speed_hs   (speed_hs),
        .fits       (fits)
    );

    txg_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (pkt_req),
        .fits         (fits),
        .stream_off   (stream_off),
        .burst        (burst_posted),
        .thr          (thr),
        .start_packet (start_packet),
        .backoff      (backoff),
        .fifo_flush   (fifo_flush),
        .bo_evt       (bo_evt)
    );
endmodule

// File: rtl/usb_txfill_gate_chk.sv
`timescale 1ns/1ps
// usb_txfill_gate_chk: cycle-by-cycle properties of the gate's ports,
// attached by bind. Assumes the field positions of the control word.
module usb_txfill_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [31:0] cfg_rd_data,
    input logic        start_packet,
    input logic        backoff
);
    logic [4:0] health;
    always_comb health = cfg_rd_data[12:8];

    assert_no_start_with_backoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_packet && backoff));

    assert_backoff_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        backoff |=> !backoff);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data[15:13] == 3'd0) && (cfg_rd_data[31:22] == 10'd0));

    assert_health_increment_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (backoff && !$past(cfg_wr_en) && ($past(health) != 5'd31))
            |-> (health == $past(health) + 5'd1));

    assert_health_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (backoff && !$past(cfg_wr_en) && ($past(health) == 5'd31)) |-> (health == 5'd31));

    assert_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> (health == 5'd0));
endmodule

bind usb_txfill_gate usb_txfill_gate_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_rd_data  (cfg_rd_data),
    .start_packet (start_packet),
    .backoff      (backoff)
);

// File: tb/usb_txfill_gate_tb_top.sv
`timescale 1ns/1ps
// usb_txfill_gate_tb_top: sweeps admission budget, thresholds, bypass and
// back-off behaviour; expected values are computed from the requirements.
module usb_txfill_gate_tb_top;
    localparam int HS_M = 2;
    localparam int FS_M = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        speed_hs = 1'b1;
    logic        stream_off = 1'b0;
    logic        pkt_req = 1'b0;
    logic [15:0] frame_left = 16'd1000;
    logic [15:0] pkt_est = 16'd10;
    logic        burst_posted = 1'b0;
    logic        start_packet, backoff, fifo_flush;

    int total = 0;
    int bad = 0;
    int model_health = 0;

    usb_txfill_gate dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_data  (cfg_wr_data),
        .cfg_rd_data  (cfg_rd_data),
        .speed_hs     (speed_hs),
        .stream_off   (stream_off),
        .pkt_req      (pkt_req),
        .frame_left   (frame_left),
        .pkt_est      (pkt_est),
        .burst_posted (burst_posted),
        .start_packet (start_packet),
        .backoff      (backoff),
        .fifo_flush   (fifo_flush)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input int ovh, input int thr);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = 32'(ovh & 255) | (32'(thr & 63) << 16) | 32'h0000_1F00;
        step();
        cfg_wr_en   = 1'b0;
        cfg_wr_data = '0;
        model_health = 0;
    endtask

    task automatic idle_bursts(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            burst_posted = 1'b1;
            step();
            burst_posted = 1'b0;
            chk(req, {30'd0, start_packet, backoff}, 0);
        end
    endtask

    // Accepted attempt, expecting release after exp bursts; gaps between bursts.
    task automatic fill_run(input int exp, input int gap, input string req);
        pkt_req = 1'b1;
        step();
        pkt_req = 1'b0;
        chk(req, {30'd0, start_packet, backoff}, 0);
        for (int i = 1; i <= exp; i++) begin
            for (int g = 0; g < gap; g++) begin
                step();
                chk(req, int'(start_packet), 0);
            end
            burst_posted = 1'b1;
            step();
            burst_posted = 1'b0;
            chk(req, int'(start_packet), (i == exp) ? 1 : 0);
        end
        step();
        chk(req, int'(start_packet), 0);
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset word
        chk("R1", int'(cfg_rd_data), 32'h0002_0000);
        // R5 default threshold 2
        fill_run(2, 0, "R5");

        // R2 layout and write
        wr(8'hA5, 6'h2B);
        chk("R2", int'(cfg_rd_data), 32'h002B_00A5);
        wr(8'hFF, 6'h3F);
        chk("R2", int'(cfg_rd_data), 32'h003F_00FF);

        // R5/R6 threshold sweep with varying gaps
        wr(0, 0);
        frame_left = 16'd1000;
        for (int t = 0; t <= 7; t++) begin
            wr(0, t);
            fill_run((t < 2) ? 2 : t, t % 3, (t < 2) ? "R6" : "R5");
        end

        // R3/R4 admission boundary sweep
        for (int sp = 0; sp < 2; sp++) begin
            for (int oi = 0; oi < 4; oi++) begin
                for (int ei = 0; ei < 2; ei++) begin
                    int ovh, est, need;
                    ovh = (oi == 0) ? 0 : (oi == 1) ? 1 : (oi == 2) ? 5 : 200;
                    est = (ei == 0) ? 0 : 37;
                    need = est + ovh * ((sp == 1) ? HS_M : FS_M);
                    speed_hs = sp[0];
                    pkt_est = 16'(est);
                    wr(ovh, 2);
                    if (need > 0) begin
                        frame_left = 16'(need - 1);
                        pkt_req = 1'b1;
                        step();
                        pkt_req = 1'b0;
                        chk("R3", {30'd0, start_packet, backoff}, 0);
                        idle_bursts(3, "R3");
                    end
                    frame_left = 16'(need);
                    fill_run(2, 0, "R4");
                end
            end
        end

        // R7 bypass at admission
        speed_hs = 1'b1;
        pkt_est = 16'd10;
        frame_left = 16'd1000;
        wr(4, 6);
        stream_off = 1'b1;
        pkt_req = 1'b1;
        step();
        pkt_req = 1'b0;
        chk("R7", int'(start_packet), 1);
        step();
        chk("R7", int'(start_packet), 0);
        stream_off = 1'b0;
        // R7 bypass raised mid-fill
        pkt_req = 1'b1;
        step();
        pkt_req = 1'b0;
        burst_posted = 1'b1;
        step();
        burst_posted = 1'b0;
        chk("R7", int'(start_packet), 0);
        stream_off = 1'b1;
        step();
        stream_off = 1'b0;
        chk("R7", int'(start_packet), 1);
        step();

        // R11 idle bursts ignored, then re-request during fill ignored
        wr(4, 3);
        idle_bursts(5, "R11");
        pkt_req = 1'b1;
        step();
        pkt_req = 1'b0;
        burst_posted = 1'b1;
        step();
        burst_posted = 1'b0;
        chk("R11", int'(start_packet), 0);
        pkt_req = 1'b1;
        step();
        pkt_req = 1'b0;
        chk("R11", int'(start_packet), 0);
        burst_posted = 1'b1;
        step();
        chk("R11", int'(start_packet), 0);
        step();
        burst_posted = 1'b0;
        chk("R11", int'(start_packet), 1);
        step();

        // R8/R9 back-offs up to and past saturation (need = 10 + 4*2 = 18)
        for (int k = 0; k < 34; k++) begin
            frame_left = 16'd18;
            pkt_req = 1'b1;
            step();
            pkt_req = 1'b0;
            burst_posted = 1'b1;
            step();
            burst_posted = 1'b0;
            frame_left = 16'd17;
            step();
            if (model_health < 31) model_health++;
            chk("R8", {29'd0, backoff, fifo_flush, start_packet}, 6);
            chk("R9", int'(cfg_rd_data[12:8]), model_health);
            step();
            chk("R8", {29'd0, backoff, fifo_flush, start_packet}, 0);
            burst_posted = 1'b1;
            step();
            step();
            burst_posted = 1'b0;
            chk("R8", int'(start_packet), 0);
        end

        // R10 write clears, including a write at the back-off edge
        wr(4, 3);
        chk("R10", int'(cfg_rd_data[12:8]), 0);
        frame_left = 16'd18;
        pkt_req = 1'b1;
        step();
        pkt_req = 1'b0;
        frame_left = 16'd17;
        cfg_wr_en = 1'b1;
        cfg_wr_data = 32'h0003_0004;
        step();
        cfg_wr_en = 1'b0;
        chk("R10", {30'd0, backoff, start_packet}, 2);
        chk("R10", int'(cfg_rd_data[12:8]), 0);
        step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule